// File: doc/BRIEF.md
# External Interrupt Edge and Wake-Up Selector

This block sits between the external interrupt pins and the interrupt controller. It takes four edge-sensitive pins and a key port. Each pin passes through a synchronizer. The block then applies a programmable edge direction and emits single-cycle request pulses on three lines: a primary external request, a secondary external request, and a counter-pin request. The counter request can come from either of two counter pins, and a configuration bit picks which one.

While the chip is powered down, the secondary request line can serve as a key wake-up source instead. In that mode it fires when any key pin configured as an input is pulled low. When wake-up mode is enabled outside power-down, the line stays silent. Software sets all of this through one 8-bit configuration register on a simple write bus. The register can be read back at all times.

Top module: `ext_irq_edge_sel`

## Requirements
- R1: After a synchronous reset the configuration reads 0x00 and no request is raised while the pins rest high.
- R2: A change on the primary pin gives one `int0_req` pulse, visible in the second cycle after the pin changes. The pulse fires on a falling edge when config bit 0 is 0 and on a rising edge when bit 0 is 1. Holding a level gives no further pulse.
- R3: When config bit 5 is 0, `int1_req` pulses once on each edge of the secondary pin in the direction set by bit 1 (0 = falling, 1 = rising). This holds whatever the state of `pdown`.
- R4: `cntr_req` pulses once on each edge of the selected counter pin in the direction set by bit 2 (0 = falling, 1 = rising). Bit 4 = 0 selects `cntr0_pin` and bit 4 = 1 selects `cntr1_pin`. The unselected pin has no effect.
- R5: When bit 5 is 1 and `pdown` is 1, `int1_req` is a key wake-up pulse. It fires once when the count of key pins that are low with direction bit 0 (input) goes from zero to nonzero. Key pins whose direction bit is 1 (output) are ignored.
- R6: When bit 5 is 1 and `pdown` is 0, `int1_req` stays low.
- R7: Writing the configuration (polarity or select bits) creates no request unless a synchronized pin level actually changes.
- R8: `reg_rdata` returns the last written value with bits 3, 6 and 7 forced to 0, starting the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int0_pin | input | 1 | Primary external interrupt pin (asynchronous) |
| int1_pin | input | 1 | Secondary external interrupt pin (asynchronous) |
| cntr0_pin | input | 1 | Counter pin A (asynchronous) |
| cntr1_pin | input | 1 | Counter pin B (asynchronous) |
| key_pin | input | KEY_W | Key port levels (asynchronous) |
| key_dir | input | KEY_W | Key port direction, 1 = output, 0 = input |
| pdown | input | 1 | Power-down status |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read-back |
| int0_req | output | 1 | Primary request pulse |
| int1_req | output | 1 | Secondary or key wake-up request pulse |
| cntr_req | output | 1 | Counter pin request pulse |

## Verification
The bench builds the block with `KEY_W = 4` and `SYNC_STAGES = 2`. With only four key pins, random flips often bring the port back to the state where every input pin is high, so the zero-to-nonzero wake-up transition recurs many times. Random direction changes also mask and unmask pins while some of them are low. Keeping two synchronizer stages fixes the pin-to-pulse latency the reference model expects. Random configuration writes fall near pin edges, which covers reloads that coincide with a real level change.

// File: rtl/ext_irq_pkg.sv
// Package: shared constants for the external interrupt selector.
// Assumes an 8-bit configuration register; bit positions are fixed here.
package ext_irq_pkg;
    localparam int CFG_W        = 8;
    localparam int NUM_CH       = 3;   // primary, secondary, counter
    localparam int PIN_W        = 4;   // int0, int1, cntr0, cntr1
    localparam int B_POL_INT0   = 0;
    localparam int B_POL_INT1   = 1;
    localparam int B_POL_CNTR   = 2;
    localparam int B_CNTR_SEL   = 4;
    localparam int B_KEY_EN     = 5;
    localparam logic [CFG_W-1:0] CFG_MASK = 8'h37;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage synchronizer for asynchronous pins.
// Assumes STAGES >= 1; every stage resets to RST_VAL.
module irq_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the pin value one stage deeper per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[gi] <= RST_VAL;
                else if (gi == 0)
                    stg[gi] <= d;
                else
                    stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
// Module: polarity-selectable edge detector with history reload.
// Assumes the level input is synchronous. The history holds the
// polarity-adjusted level, so a reload with a new polarity or
// source blocks a false edge on the next cycle.
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,      // synchronized level
    input  logic pol,      // 0 = falling, 1 = rising
    input  logic reload,   // configuration write this cycle
    input  logic rl_lvl,   // level as seen under new configuration
    input  logic rl_pol,   // polarity after the write
    output logic req
);
    logic act;
    logic prev_q;

    // Map the level so that a qualifying edge is always 0 -> 1.
    always_comb act = pol ? lvl : ~lvl;

    // Track history; on a write, reload it as seen by the new setting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (reload)
            prev_q <= rl_pol ? rl_lvl : ~rl_lvl;
        else
            prev_q <= act;
    end

    assign req = act & ~prev_q;
endmodule

// File: rtl/irq_key_wake.sv
// Module: key port any-low detector giving a single entry pulse.
// Assumes synchronized key levels; direction bit 1 marks an output pin.
module irq_key_wake #(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_lvl,
    input  logic [KEY_W-1:0] key_dir,
    output logic             pulse
);
    logic any_low;
    logic prev_q;

    // Any input-mode pin held low.
    always_comb any_low = |(~key_lvl & ~key_dir);

    // Remember last cycle's condition to pulse only on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= any_low;
    end

    assign pulse = any_low & ~prev_q;
endmodule

// File: rtl/ext_irq_edge_sel.sv
// Module: external interrupt edge and wake-up selector (top).
// Assumes pins idle high at reset and that pdown, key_dir and the
// register bus are synchronous to clk.
module ext_irq_edge_sel
    import ext_irq_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int0_pin,
    input  logic             int1_pin,
    input  logic             cntr0_pin,
    input  logic             cntr1_pin,
    input  logic [KEY_W-1:0] key_pin,
    input  logic [KEY_W-1:0] key_dir,
    input  logic             pdown,
    input  logic             reg_wr,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    output logic             int0_req,
    output logic             int1_req,
    output logic             cntr_req
);
    localparam int SYNC_W = PIN_W + KEY_W;

    logic [SYNC_W-1:0] sync_q;
    logic [PIN_W-1:0]  pin_s;
    logic [KEY_W-1:0]  key_s;
    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_next;
    logic [NUM_CH-1:0] ch_lvl, ch_rl_lvl, ch_pol, ch_rl_pol, ch_req;
    logic              key_pulse;

    irq_sync #(
        .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({key_pin, cntr1_pin, cntr0_pin, int1_pin, int0_pin}),
        .q(sync_q)
    );

    assign pin_s = sync_q[PIN_W-1:0];
    assign key_s = sync_q[SYNC_W-1:PIN_W];

    // Masked value a write would store.
    always_comb cfg_next = reg_wdata & CFG_MASK;

    // Configuration register with reserved bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (reg_wr)
            cfg_q <= cfg_next;
    end

    assign reg_rdata = cfg_q;

    // Per-channel source level and polarity, current and after write.
    always_comb begin
        ch_lvl[0]    = pin_s[0];
        ch_lvl[1]    = pin_s[1];
        ch_lvl[2]    = cfg_q[B_CNTR_SEL] ? pin_s[3] : pin_s[2];
        ch_rl_lvl[0] = pin_s[0];
        ch_rl_lvl[1] = pin_s[1];
        ch_rl_lvl[2] = cfg_next[B_CNTR_SEL] ? pin_s[3] : pin_s[2];
        ch_pol       = {cfg_q[B_POL_CNTR], cfg_q[B_POL_INT1], cfg_q[B_POL_INT0]};
        ch_rl_pol    = {cfg_next[B_POL_CNTR], cfg_next[B_POL_INT1], cfg_next[B_POL_INT0]};
    end

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            irq_edge_det u_edge (
                .clk(clk), .rst_n(rst_n),
                .lvl(ch_lvl[gc]), .pol(ch_pol[gc]),
                .reload(reg_wr), .rl_lvl(ch_rl_lvl[gc]), .rl_pol(ch_rl_pol[gc]),
                .req(ch_req[gc])
            );
        end
    endgenerate

    irq_key_wake #(.KEY_W(KEY_W)) u_key (
        .clk(clk), .rst_n(rst_n),
        .key_lvl(key_s), .key_dir(key_dir),
        .pulse(key_pulse)
    );

    // Route outputs; the secondary line depends on wake-up mode.
    always_comb begin
        int0_req = ch_req[0];
        cntr_req = ch_req[2];
        if (cfg_q[B_KEY_EN])
            int1_req = pdown & key_pulse;
        else
            int1_req = ch_req[1];
    end
endmodule

// File: rtl/ext_irq_edge_sel_chk.sv
// Module: protocol checker for the external interrupt selector.
// Assumes it is bound to the top and sees only its ports.
module ext_irq_edge_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pdown,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       int0_req,
    input logic       int1_req,
    input logic       cntr_req
);
    AST_INT0_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int0_req && !reg_wr) |=> !int0_req); // R2
    AST_CNTR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cntr_req && !reg_wr) |=> !cntr_req); // R4
    AST_KEY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_req && pdown && reg_rdata[5] && !reg_wr) |=> !(int1_req && pdown && reg_rdata[5])); // R5
    AST_INT1_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5] && !pdown) |-> !int1_req); // R6
    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == ($past(reg_wdata) & 8'h37))); // R8
endmodule

bind ext_irq_edge_sel ext_irq_edge_sel_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pdown(pdown), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int0_req(int0_req), .int1_req(int1_req), .cntr_req(cntr_req)
);

// File: tb/ext_irq_edge_sel_tb_top.sv
module ext_irq_edge_sel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KEY_W      = 4;
    localparam int MAX_CYC    = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             rst_n;
    logic             int0_pin, int1_pin, cntr0_pin, cntr1_pin;
    logic [KEY_W-1:0] key_pin, key_dir;
    logic             pdown, reg_wr;
    logic [7:0]       reg_wdata, reg_rdata;
    logic             int0_req, int1_req, cntr_req;

    ext_irq_edge_sel #(.KEY_W(KEY_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .int0_pin(int0_pin), .int1_pin(int1_pin),
        .cntr0_pin(cntr0_pin), .cntr1_pin(cntr1_pin),
        .key_pin(key_pin), .key_dir(key_dir), .pdown(pdown),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int0_req(int0_req), .int1_req(int1_req), .cntr_req(cntr_req)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Reference model state (bench-side view of the requirements)
    logic [3:0]       m_s1, m_s2;
    logic [KEY_W-1:0] m_k1, m_k2;
    logic [2:0]       m_prev;
    logic             m_kprev;
    logic [7:0]       m_cfg;
    logic             m_wrote;

    function automatic logic act(input logic l, input logic p);
        return p ? l : ~l;
    endfunction

    function automatic logic any_low(input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] d);
        return |(~k & ~d);
    endfunction

    task automatic check(input string tag, input logic [7:0] a, input logic [7:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, a, e, $time);
        end
    endtask

    // Advance the model by the posedge just passed, then compare outputs.
    task automatic model_step();
        logic [7:0] ncfg;
        logic e0, e1, ec, ek;
        string t1;
        if (!rst_n) begin
            m_s1 = 4'hF; m_s2 = 4'hF; m_k1 = '1; m_k2 = '1;
            m_prev = '0; m_kprev = 1'b0; m_cfg = '0; m_wrote = 1'b0;
        end else begin
            ncfg = reg_wr ? (reg_wdata & 8'h37) : m_cfg;
            m_prev[0] = act(m_s2[0], ncfg[0]);
            m_prev[1] = act(m_s2[1], ncfg[1]);
            m_prev[2] = act(ncfg[4] ? m_s2[3] : m_s2[2], ncfg[2]);
            m_kprev   = any_low(m_k2, key_dir);
            m_s2 = m_s1;
            m_s1 = {cntr1_pin, cntr0_pin, int1_pin, int0_pin};
            m_k2 = m_k1;
            m_k1 = key_pin;
            m_cfg = ncfg;
            m_wrote = reg_wr;
        end
        e0 = act(m_s2[0], m_cfg[0]) & ~m_prev[0];
        ec = act(m_cfg[4] ? m_s2[3] : m_s2[2], m_cfg[2]) & ~m_prev[2];
        ek = any_low(m_k2, key_dir) & ~m_kprev;
        e1 = m_cfg[5] ? (pdown & ek) : (act(m_s2[1], m_cfg[1]) & ~m_prev[1]);
        if (!rst_n) begin
            check("R1 rdata", reg_rdata, 8'h00);
            check("R1 reqs", {5'd0, int0_req, int1_req, cntr_req}, 8'h00);
        end else begin
            t1 = m_cfg[5] ? (pdown ? "R5 key wake" : "R6 muted") : "R3 int1 edge";
            if (m_wrote) begin
                check("R7 int0 after write", {7'd0, int0_req}, {7'd0, e0});
                check("R7 cntr after write", {7'd0, cntr_req}, {7'd0, ec});
            end else begin
                check("R2 int0", {7'd0, int0_req}, {7'd0, e0});
                check("R4 cntr", {7'd0, cntr_req}, {7'd0, ec});
            end
            check(t1, {7'd0, int1_req}, {7'd0, e1});
            check("R8 rdata", reg_rdata, m_cfg);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
    endtask

    task automatic write_cfg(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        int0_pin = 1'b1; int1_pin = 1'b1; cntr0_pin = 1'b1; cntr1_pin = 1'b1;
        key_pin = '1; key_dir = '0; pdown = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) tick();                           // R1 reset checks
        rst_n = 1'b1;
        repeat (3) tick();

        // R2: falling edge with polarity 0, then hold low
        int0_pin = 1'b0; repeat (4) tick();
        int0_pin = 1'b1; repeat (3) tick();
        // R8: reserved bits masked on read-back
        write_cfg(8'hFF); tick();
        // R7: flip every polarity and the select with pins steady
        write_cfg(8'h00); repeat (3) tick();
        write_cfg(8'h17); repeat (3) tick();
        // R4: unselected counter pin ignored, selected one fires
        cntr0_pin = 1'b0; repeat (3) tick();
        cntr1_pin = 1'b0; repeat (3) tick();
        cntr1_pin = 1'b1; repeat (3) tick();
        // R5: output-mode key low ignored, input-mode key low wakes once
        write_cfg(8'h20); pdown = 1'b1;
        key_dir = 4'b0001; key_pin = 4'b1110; repeat (3) tick();
        key_pin = 4'b1100; repeat (4) tick();
        key_pin = 4'b1111; repeat (3) tick();
        // R6: wake-up mode outside power-down stays silent
        pdown = 1'b0; int1_pin = 1'b0; key_pin = 4'b0000; repeat (4) tick();
        int1_pin = 1'b1; key_pin = '1; key_dir = '0;
        // R3: normal edge path during power-down
        write_cfg(8'h02); pdown = 1'b1; repeat (3) tick();
        int1_pin = 1'b0; repeat (3) tick();
        int1_pin = 1'b1; repeat (3) tick();

        // Constrained random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 6 == 0) int0_pin  = ~int0_pin;
            if ($urandom % 6 == 0) int1_pin  = ~int1_pin;
            if ($urandom % 6 == 0) cntr0_pin = ~cntr0_pin;
            if ($urandom % 6 == 0) cntr1_pin = ~cntr1_pin;
            if ($urandom % 4 == 0) key_pin[$urandom % KEY_W] = ~key_pin[$urandom % KEY_W];
            if ($urandom % 5 == 0) key_pin = '1;
            if ($urandom % 40 == 0) key_dir = KEY_W'($urandom);
            if ($urandom % 50 == 0) pdown = ~pdown;
            reg_wr = ($urandom % 16 == 0);
            reg_wdata = 8'($urandom);
            tick();
        end
        reg_wr = 1'b0;
        repeat (4) tick();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule